// File: doc/BRIEF.md
# Peripheral pin override generator

This block sits between a set of on-chip peripherals and the general-purpose pin cells. From the peripherals' enable and mode signals it works out, for every pin, whether the pull-up, the driver direction, the driven value and the digital input enable are taken away from the software port settings, and what they are forced to. Each of the four controls is a pair of vectors: an enable saying "override this pin" and a value saying what to force. A pin cell uses the value when the matching enable bit is set and its own register bits when it is clear.

The peripherals covered are:
- a serial peripheral interface with clock, controller-out, controller-in and select pins, working as controller or target;
- a UART with separate transmit and receive pins;
- two external interrupt lines;
- a two-wire bus with clock and data pins;
- three timer compare outputs. The first shares the controller-out pin with the serial peripheral interface, the second shares the select pin, and the third has a pin of its own.

The enable and mode inputs are captured in flops, so a change in them shows at the outputs one clock later. The data inputs pass straight through the combinational logic. These data inputs are the serial clock and data, the transmit bit, the bus drive requests, the compare levels, the port bits and the global pull-up disable. Pin positions are parameters.

Top module: `pin_override_gen`

## Requirements
- R1: The enable and mode inputs (`spi_en_i`, `spi_master_i`, `uart_tx_en_i`, `uart_rx_en_i`, `irq_en_i`, `twi_en_i`, `cmp_en_i`) act on the outputs one clock edge after they are applied. While `rst_n` is low every output bit is 0.
- R2: With `spi_en_i`=1 and `spi_master_i`=0 (target), the clock, controller-out and select pins (default indices 5, 3 and 2) are forced to input: direction enable 1, direction value 0, pull-up enable 1. The pull-up value is their port bit AND NOT `pull_dis_i`. The controller-in pin (index 4) gets a port-value override equal to `spi_sdo_i`.
- R3: With `spi_en_i`=1 and `spi_master_i`=1 (controller), the controller-in pin is forced to input with the same pull-up rule as R2. The clock pin's port value is overridden with `spi_sck_i`.
- R4: A serial peripheral interface pin that the current role does not force to input has direction override enable 0, so it keeps the direction register setting. In target mode this is the controller-in pin; in controller mode it is the clock, controller-out and select pins.
- R5: With `uart_tx_en_i`=1 the transmit pin (index 9) has pull-up enable 1 with value 0, direction forced to output (enable 1, value 1), and its port value forced to `uart_txd_i`.
- R6: With `uart_rx_en_i`=1 the receive pin (index 8) is forced to input. Its pull-up is forced to its port bit AND NOT `pull_dis_i`.
- R7: On the controller-out pin the port-value override enable is (`spi_en_i` AND `spi_master_i`) OR `cmp_en_i[0]`. The override value is `spi_sdo_i` OR `cmp_out_i[0]`.
- R8: Compare output 1 overrides the select pin's port value with `cmp_out_i[1]` when `cmp_en_i[1]`=1. Compare output 2 does the same on its own pin (index 1) with `cmp_out_i[2]` when `cmp_en_i[2]`=1.
- R9: On interrupt pins 0 and 1 (indices 10 and 11) the input-enable override enable equals `irq_en_i[0]` and `irq_en_i[1]` respectively, and the override value is 1.
- R10: With `twi_en_i`=1 the data and clock pins (indices 12 and 13) get pull-up, direction and port-value overrides. The port value is forced to 0, and the direction value equals `twi_sda_drv_i` / `twi_scl_drv_i`, which gives an open-drain driver. The pull-up value is the port bit AND NOT `pull_dis_i`.
- R11: Every override value bit is 0 whenever its enable bit is 0. A pin that no peripheral claims has all override enables at 0 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_en_i | input | 1 | Serial peripheral interface enable |
| spi_master_i | input | 1 | 1 = controller role, 0 = target role |
| uart_tx_en_i | input | 1 | UART transmitter enable |
| uart_rx_en_i | input | 1 | UART receiver enable |
| irq_en_i | input | 2 | External interrupt enables |
| twi_en_i | input | 1 | Two-wire bus enable |
| cmp_en_i | input | 3 | Timer compare output enables |
| spi_sck_i | input | 1 | Serial clock driven in controller role |
| spi_sdo_i | input | 1 | Serial data out of the peripheral |
| uart_txd_i | input | 1 | UART transmit bit |
| twi_scl_drv_i | input | 1 | 1 = pull clock line low |
| twi_sda_drv_i | input | 1 | 1 = pull data line low |
| cmp_out_i | input | 3 | Timer compare levels |
| port_bits_i | input | NPIN | Port data register bits |
| pull_dis_i | input | 1 | Global pull-up disable |
| pu_ovr_en_o | output | NPIN | Pull-up override enable |
| pu_ovr_val_o | output | NPIN | Pull-up override value |
| dir_ovr_en_o | output | NPIN | Direction override enable |
| dir_ovr_val_o | output | NPIN | Direction override value (1 = output) |
| val_ovr_en_o | output | NPIN | Port-value override enable |
| val_ovr_val_o | output | NPIN | Port-value override value |
| die_ovr_en_o | output | NPIN | Digital input enable override enable |
| die_ovr_val_o | output | NPIN | Digital input enable override value |

## Verification
The bench builds the block with its default parameters: 16 pins, with the peripheral pins at indices 1 to 5 and 8 to 13 and the others left unclaimed. With only ten enable bits, all 1024 enable combinations can be swept under two data patterns, and every output vector is compared each time. This covers every overlap, such as target mode with compare 0, or the transmitter and receiver at once. It also checks that unclaimed pins 0, 6, 7, 14 and 15 stay at zero throughout.

// File: rtl/pin_override_gen.sv
module pin_override_gen #(
  parameter int NPIN   = 16,
  parameter int P_CMPC = 1,
  parameter int P_SS   = 2,
  parameter int P_MOSI = 3,
  parameter int P_MISO = 4,
  parameter int P_SCK  = 5,
  parameter int P_RXD  = 8,
  parameter int P_TXD  = 9,
  parameter int P_INT0 = 10,
  parameter int P_INT1 = 11,
  parameter int P_SDA  = 12,
  parameter int P_SCL  = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spi_en_i,
  input  logic            spi_master_i,
  input  logic            uart_tx_en_i,
  input  logic            uart_rx_en_i,
  input  logic [1:0]      irq_en_i,
  input  logic            twi_en_i,
  input  logic [2:0]      cmp_en_i,
  input  logic            spi_sck_i,
  input  logic            spi_sdo_i,
  input  logic            uart_txd_i,
  input  logic            twi_scl_drv_i,
  input  logic            twi_sda_drv_i,
  input  logic [2:0]      cmp_out_i,
  input  logic [NPIN-1:0] port_bits_i,
  input  logic            pull_dis_i,
  output logic [NPIN-1:0] pu_ovr_en_o,
  output logic [NPIN-1:0] pu_ovr_val_o,
  output logic [NPIN-1:0] dir_ovr_en_o,
  output logic [NPIN-1:0] dir_ovr_val_o,
  output logic [NPIN-1:0] val_ovr_en_o,
  output logic [NPIN-1:0] val_ovr_val_o,
  output logic [NPIN-1:0] die_ovr_en_o,
  output logic [NPIN-1:0] die_ovr_val_o
);

  logic       spi_en_q, master_q, tx_en_q, rx_en_q, twi_en_q;
  logic [1:0] irq_en_q;
  logic [2:0] cmp_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spi_en_q <= 1'b0;
      master_q <= 1'b0;
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      twi_en_q <= 1'b0;
      irq_en_q <= '0;
      cmp_en_q <= '0;
    end else begin
      spi_en_q <= spi_en_i;
      master_q <= spi_master_i;
      tx_en_q  <= uart_tx_en_i;
      rx_en_q  <= uart_rx_en_i;
      twi_en_q <= twi_en_i;
      irq_en_q <= irq_en_i;
      cmp_en_q <= cmp_en_i;
    end
  end

  wire ctl = spi_en_q & master_q;
  wire tgt = spi_en_q & ~master_q;
  wire [NPIN-1:0] keep_pu = port_bits_i & ~{NPIN{pull_dis_i}};

  logic [NPIN-1:0] pue, puv, de, dv, ve, vv, ie, iv;

  always_comb begin
    pue = '0; puv = '0; de = '0; dv = '0;
    ve  = '0; vv  = '0; ie = '0; iv = '0;

    pue[P_SCK]  = tgt;  puv[P_SCK]  = tgt & keep_pu[P_SCK];
    de[P_SCK]   = tgt;
    ve[P_SCK]   = ctl;  vv[P_SCK]   = ctl & spi_sck_i;

    pue[P_MISO] = ctl;  puv[P_MISO] = ctl & keep_pu[P_MISO];
    de[P_MISO]  = ctl;
    ve[P_MISO]  = tgt;  vv[P_MISO]  = tgt & spi_sdo_i;

    pue[P_MOSI] = tgt;  puv[P_MOSI] = tgt & keep_pu[P_MOSI];
    de[P_MOSI]  = tgt;
    ve[P_MOSI]  = ctl | cmp_en_q[0];
    vv[P_MOSI]  = (ctl | cmp_en_q[0]) & (spi_sdo_i | cmp_out_i[0]);

    pue[P_SS]   = tgt;  puv[P_SS]   = tgt & keep_pu[P_SS];
    de[P_SS]    = tgt;
    ve[P_SS]    = cmp_en_q[1]; vv[P_SS] = cmp_en_q[1] & cmp_out_i[1];

    ve[P_CMPC]  = cmp_en_q[2]; vv[P_CMPC] = cmp_en_q[2] & cmp_out_i[2];

    pue[P_TXD]  = tx_en_q;
    de[P_TXD]   = tx_en_q;  dv[P_TXD] = tx_en_q;
    ve[P_TXD]   = tx_en_q;  vv[P_TXD] = tx_en_q & uart_txd_i;

    pue[P_RXD]  = rx_en_q;  puv[P_RXD] = rx_en_q & keep_pu[P_RXD];
    de[P_RXD]   = rx_en_q;

    ie[P_INT0]  = irq_en_q[0]; iv[P_INT0] = irq_en_q[0];
    ie[P_INT1]  = irq_en_q[1]; iv[P_INT1] = irq_en_q[1];

    pue[P_SDA]  = twi_en_q; puv[P_SDA] = twi_en_q & keep_pu[P_SDA];
    de[P_SDA]   = twi_en_q; dv[P_SDA]  = twi_en_q & twi_sda_drv_i;
    ve[P_SDA]   = twi_en_q;

    pue[P_SCL]  = twi_en_q; puv[P_SCL] = twi_en_q & keep_pu[P_SCL];
    de[P_SCL]   = twi_en_q; dv[P_SCL]  = twi_en_q & twi_scl_drv_i;
    ve[P_SCL]   = twi_en_q;
  end

  assign pu_ovr_en_o   = pue;
  assign pu_ovr_val_o  = puv;
  assign dir_ovr_en_o  = de;
  assign dir_ovr_val_o = dv;
  assign val_ovr_en_o  = ve;
  assign val_ovr_val_o = vv;
  assign die_ovr_en_o  = ie;
  assign die_ovr_val_o = iv;

endmodule

// File: rtl/pin_override_gen_chk.sv
module pin_override_gen_chk #(
  parameter int NPIN   = 16,
  parameter int P_CMPC = 1,
  parameter int P_SS   = 2,
  parameter int P_MOSI = 3,
  parameter int P_MISO = 4,
  parameter int P_SCK  = 5,
  parameter int P_RXD  = 8,
  parameter int P_TXD  = 9,
  parameter int P_INT0 = 10,
  parameter int P_INT1 = 11,
  parameter int P_SDA  = 12,
  parameter int P_SCL  = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            spi_en_i,
  input logic            spi_master_i,
  input logic            uart_tx_en_i,
  input logic            uart_rx_en_i,
  input logic [1:0]      irq_en_i,
  input logic            twi_en_i,
  input logic [2:0]      cmp_en_i,
  input logic [NPIN-1:0] pu_ovr_en_o,
  input logic [NPIN-1:0] pu_ovr_val_o,
  input logic [NPIN-1:0] dir_ovr_en_o,
  input logic [NPIN-1:0] dir_ovr_val_o,
  input logic [NPIN-1:0] val_ovr_en_o,
  input logic [NPIN-1:0] val_ovr_val_o,
  input logic [NPIN-1:0] die_ovr_en_o,
  input logic [NPIN-1:0] die_ovr_val_o
);

  localparam logic [NPIN-1:0] ONE = {{(NPIN-1){1'b0}}, 1'b1};
  localparam logic [NPIN-1:0] CLAIMED =
    (ONE << P_CMPC) | (ONE << P_SS) | (ONE << P_MOSI) | (ONE << P_MISO) |
    (ONE << P_SCK) | (ONE << P_RXD) | (ONE << P_TXD) | (ONE << P_INT0) |
    (ONE << P_INT1) | (ONE << P_SDA) | (ONE << P_SCL);

  wire [NPIN-1:0] any_en = pu_ovr_en_o | dir_ovr_en_o | val_ovr_en_o | die_ovr_en_o;

  AST_UNCLAIMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (any_en & ~CLAIMED) == '0); // R11
  AST_VALUE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((pu_ovr_val_o & ~pu_ovr_en_o) | (dir_ovr_val_o & ~dir_ovr_en_o) |
     (val_ovr_val_o & ~val_ovr_en_o) | (die_ovr_val_o & ~die_ovr_en_o)) == '0); // R11
  AST_TARGET_INPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en_i && !spi_master_i) |=> (dir_ovr_en_o[P_SCK] && !dir_ovr_val_o[P_SCK] &&
      dir_ovr_en_o[P_MOSI] && dir_ovr_en_o[P_SS] && pu_ovr_en_o[P_SS] &&
      !dir_ovr_en_o[P_MISO])); // R2
  AST_CTRL_MISO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en_i && spi_master_i) |=> (dir_ovr_en_o[P_MISO] && !dir_ovr_val_o[P_MISO] &&
      !dir_ovr_en_o[P_SCK] && val_ovr_en_o[P_MOSI])); // R3
  AST_TX_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    uart_tx_en_i |=> (dir_ovr_en_o[P_TXD] && dir_ovr_val_o[P_TXD] && val_ovr_en_o[P_TXD])); // R5
  AST_RX_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    uart_rx_en_i |=> (dir_ovr_en_o[P_RXD] && !dir_ovr_val_o[P_RXD])); // R6
  AST_IRQ_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_i[0] |=> (die_ovr_en_o[P_INT0] && die_ovr_val_o[P_INT0])); // R9
  AST_TWI_OPEN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    twi_en_i |=> (val_ovr_en_o[P_SDA] && !val_ovr_val_o[P_SDA] &&
      val_ovr_en_o[P_SCL] && !val_ovr_val_o[P_SCL])); // R10
  AST_CMP_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en_i[2] |=> val_ovr_en_o[P_CMPC]); // R8

endmodule

bind pin_override_gen pin_override_gen_chk #(
  .NPIN(NPIN), .P_CMPC(P_CMPC), .P_SS(P_SS), .P_MOSI(P_MOSI), .P_MISO(P_MISO),
  .P_SCK(P_SCK), .P_RXD(P_RXD), .P_TXD(P_TXD), .P_INT0(P_INT0), .P_INT1(P_INT1),
  .P_SDA(P_SDA), .P_SCL(P_SCL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_en_i(spi_en_i), .spi_master_i(spi_master_i),
  .uart_tx_en_i(uart_tx_en_i), .uart_rx_en_i(uart_rx_en_i), .irq_en_i(irq_en_i),
  .twi_en_i(twi_en_i), .cmp_en_i(cmp_en_i),
  .pu_ovr_en_o(pu_ovr_en_o), .pu_ovr_val_o(pu_ovr_val_o),
  .dir_ovr_en_o(dir_ovr_en_o), .dir_ovr_val_o(dir_ovr_val_o),
  .val_ovr_en_o(val_ovr_en_o), .val_ovr_val_o(val_ovr_val_o),
  .die_ovr_en_o(die_ovr_en_o), .die_ovr_val_o(die_ovr_val_o)
);

// File: tb/sim_pin_override_gen.sv
`timescale 1ns/1ps
module sim_pin_override_gen;
  localparam int N = 16;
  localparam int CMPC = 1, SS = 2, MOSI = 3, MISO = 4, SCK = 5;
  localparam int RXD = 8, TXD = 9, INT0 = 10, INT1 = 11, SDA = 12, SCL = 13;

  logic clk = 0, rst_n = 0;
  logic spi_en = 0, spi_master = 0, tx_en = 0, rx_en = 0, twi_en = 0;
  logic [1:0] irq_en = 0;
  logic [2:0] cmp_en = 0, cmp_out = 0;
  logic sck = 0, sdo = 0, txd = 0, scl_drv = 0, sda_drv = 0, pud = 0;
  logic [N-1:0] port = 0;
  logic [N-1:0] pue, puv, de, dv, ve, vv, ie, iv;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pin_override_gen u0 (
    .clk(clk), .rst_n(rst_n), .spi_en_i(spi_en), .spi_master_i(spi_master),
    .uart_tx_en_i(tx_en), .uart_rx_en_i(rx_en), .irq_en_i(irq_en), .twi_en_i(twi_en),
    .cmp_en_i(cmp_en), .spi_sck_i(sck), .spi_sdo_i(sdo), .uart_txd_i(txd),
    .twi_scl_drv_i(scl_drv), .twi_sda_drv_i(sda_drv), .cmp_out_i(cmp_out),
    .port_bits_i(port), .pull_dis_i(pud),
    .pu_ovr_en_o(pue), .pu_ovr_val_o(puv), .dir_ovr_en_o(de), .dir_ovr_val_o(dv),
    .val_ovr_en_o(ve), .val_ovr_val_o(vv), .die_ovr_en_o(ie), .die_ovr_val_o(iv));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    spi_en = 0; spi_master = 0; tx_en = 0; rx_en = 0; twi_en = 0;
    irq_en = 0; cmp_en = 0; cmp_out = 0; sck = 0; sdo = 0; txd = 0;
    scl_drv = 0; sda_drv = 0; pud = 0; port = 0;
  endtask

  function automatic logic [N-1:0] bitv(input int i);
    return {{(N-1){1'b0}}, 1'b1} << i;
  endfunction

  function automatic logic [8*N-1:0] ref_model();
    logic [N-1:0] a, b, c, d, e, f, g, h, k;
    logic t, m, me;
    a = 0; b = 0; c = 0; d = 0; e = 0; f = 0; g = 0; h = 0;
    k = port & ~{N{pud}};
    t = spi_en & ~spi_master;
    m = spi_en & spi_master;
    if (t) begin
      a |= bitv(SCK) | bitv(MOSI) | bitv(SS);
      b |= k & (bitv(SCK) | bitv(MOSI) | bitv(SS));
      c |= bitv(SCK) | bitv(MOSI) | bitv(SS);
      e |= bitv(MISO);
      if (sdo) f |= bitv(MISO);
    end
    if (m) begin
      a |= bitv(MISO); b |= k & bitv(MISO); c |= bitv(MISO);
      e |= bitv(SCK); if (sck) f |= bitv(SCK);
    end
    me = m | cmp_en[0];
    if (me) begin e |= bitv(MOSI); if (sdo | cmp_out[0]) f |= bitv(MOSI); end
    if (cmp_en[1]) begin e |= bitv(SS); if (cmp_out[1]) f |= bitv(SS); end
    if (cmp_en[2]) begin e |= bitv(CMPC); if (cmp_out[2]) f |= bitv(CMPC); end
    if (tx_en) begin
      a |= bitv(TXD); c |= bitv(TXD); d |= bitv(TXD); e |= bitv(TXD);
      if (txd) f |= bitv(TXD);
    end
    if (rx_en) begin a |= bitv(RXD); b |= k & bitv(RXD); c |= bitv(RXD); end
    if (irq_en[0]) begin g |= bitv(INT0); h |= bitv(INT0); end
    if (irq_en[1]) begin g |= bitv(INT1); h |= bitv(INT1); end
    if (twi_en) begin
      a |= bitv(SDA) | bitv(SCL); b |= k & (bitv(SDA) | bitv(SCL));
      c |= bitv(SDA) | bitv(SCL); e |= bitv(SDA) | bitv(SCL);
      if (sda_drv) d |= bitv(SDA);
      if (scl_drv) d |= bitv(SCL);
    end
    return {a, b, c, d, e, f, g, h};
  endfunction

  task automatic chk_all(input string tag);
    logic [8*N-1:0] r;
    r = ref_model();
    chk({tag, " pu_en"},  pue, r[8*N-1:7*N]);
    chk({tag, " pu_val"}, puv, r[7*N-1:6*N]);
    chk({tag, " dir_en"}, de,  r[6*N-1:5*N]);
    chk({tag, " dir_val"},dv,  r[5*N-1:4*N]);
    chk({tag, " val_en"}, ve,  r[4*N-1:3*N]);
    chk({tag, " val_val"},vv,  r[3*N-1:2*N]);
    chk({tag, " die_en"}, ie,  r[2*N-1:N]);
    chk({tag, " die_val"},iv,  r[N-1:0]);
  endtask

  task automatic t_reset();
    spi_en = 1; tx_en = 1; twi_en = 1; irq_en = 3; cmp_en = 7; port = '1;
    step();
    chk("R1 reset pu_en", pue, '0);
    chk("R1 reset dir_en", de, '0);
    chk("R1 reset val_en", ve, '0);
    chk("R1 reset die_en", ie, '0);
    clear_all();
  endtask

  task automatic t_latency();
    clear_all(); step();
    tx_en = 1; #1;
    chk("R1 before edge", de & bitv(TXD), '0);
    step();
    chk("R1 after edge", de & bitv(TXD), bitv(TXD));
    clear_all(); step();
  endtask

  task automatic t_target();
    clear_all(); spi_en = 1; sdo = 1; port = bitv(SCK) | bitv(SS); step();
    chk("R2 dir_en", de & (bitv(SCK)|bitv(MOSI)|bitv(SS)), bitv(SCK)|bitv(MOSI)|bitv(SS));
    chk("R2 dir_val", dv, '0);
    chk("R2 pu_val", puv, bitv(SCK) | bitv(SS));
    chk("R2 miso val", vv & bitv(MISO), bitv(MISO));
    chk("R4 miso dir kept", de & bitv(MISO), '0);
    pud = 1; #1;
    chk("R2 pull disable", puv, '0);
  endtask

  task automatic t_controller();
    clear_all(); spi_en = 1; spi_master = 1; sck = 1; port = bitv(MISO); step();
    chk("R3 miso input", de & bitv(MISO), bitv(MISO));
    chk("R3 miso pull", puv & bitv(MISO), bitv(MISO));
    chk("R3 sck value", vv & bitv(SCK), bitv(SCK));
    chk("R4 kept dirs", de & (bitv(SCK)|bitv(MOSI)|bitv(SS)), '0);
    chk_all("R3");
  endtask

  task automatic t_tx();
    clear_all(); tx_en = 1; txd = 1; port = bitv(TXD); step();
    chk("R5 tx pin", {pue[TXD], puv[TXD], de[TXD], dv[TXD], ve[TXD], vv[TXD]}, 6'b101111);
    txd = 0; #1;
    chk("R5 tx data low", vv & bitv(TXD), '0);
  endtask

  task automatic t_rx();
    clear_all(); rx_en = 1; port = bitv(RXD); step();
    chk("R6 rx pin", {pue[RXD], puv[RXD], de[RXD], dv[RXD], ve[RXD]}, 5'b11100);
  endtask

  task automatic t_shared();
    clear_all(); cmp_en = 3'b001; cmp_out = 3'b001; step();
    chk("R7 compare only", {ve[MOSI], vv[MOSI]}, 2'b11);
    cmp_out = 0; sdo = 1; #1;
    chk("R7 or of data", vv & bitv(MOSI), bitv(MOSI));
    clear_all(); spi_en = 1; cmp_out = 3'b001; step();
    chk("R7 target no claim", ve & bitv(MOSI), '0);
  endtask

  task automatic t_cmp();
    clear_all(); cmp_en = 3'b110; cmp_out = 3'b100; step();
    chk("R8 select pin", {ve[SS], vv[SS]}, 2'b10);
    chk("R8 own pin", {ve[CMPC], vv[CMPC]}, 2'b11);
  endtask

  task automatic t_irq();
    clear_all(); irq_en = 2'b10; step();
    chk("R9 irq", ie | iv, bitv(INT1) | bitv(INT1));
    chk("R9 irq0 off", ie & bitv(INT0), '0);
  endtask

  task automatic t_twi();
    clear_all(); twi_en = 1; sda_drv = 1; port = bitv(SCL); step();
    chk("R10 dir_val", dv, bitv(SDA));
    chk("R10 value zero", vv, '0);
    chk("R10 val_en", ve, bitv(SDA) | bitv(SCL));
    chk("R10 pull", puv, bitv(SCL));
  endtask

  task automatic t_sweep();
    for (int p = 0; p < 2; p++) begin
      for (int c = 0; c < 1024; c++) begin
        spi_en = c[0]; spi_master = c[1]; tx_en = c[2]; rx_en = c[3];
        irq_en = c[5:4]; twi_en = c[6]; cmp_en = c[9:7];
        if (p == 0) begin
          sck = 1; sdo = 1; txd = 1; scl_drv = 1; sda_drv = 1; cmp_out = 3'b111;
          port = '1; pud = 0;
        end else begin
          sck = c[2]; sdo = c[4]; txd = c[1]; scl_drv = c[0]; sda_drv = c[3];
          cmp_out = c[6:4]; port = ~{6'd0, c}; pud = c[5];
        end
        step();
        chk_all("R11 sweep");
        chk("R11 unclaimed", (pue|de|ve|ie) & (bitv(0)|bitv(6)|bitv(7)|bitv(14)|bitv(15)), '0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_all();
    t_reset();
    rst_n = 1;
    step();
    t_latency();
    t_target();
    t_controller();
    t_tx();
    t_rx();
    t_shared();
    t_cmp();
    t_irq();
    t_twi();
    t_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule